// File: doc/BRIEF.md
# Two-Port Hardware Lock Flags

This block holds eight binary lock flags shared by two independent agents, a left side and a right side. Each side selects a flag with a 3-bit index. It claims the flag by writing a 0 in data bit 0 and gives it up by writing a 1. It reads the flag as it appears from its own side. Flags are active low. The side that holds a flag reads it as all zeros. The other side, and both sides when nobody holds the flag, read all ones. Each side keeps its own request latch for each flag. A claim made while the other side holds the flag therefore stays pending, and it turns into ownership in the same cycle the holder releases. Software follows a write-then-read sequence: it writes 0, then reads back. A 00 means the claim succeeded.

The block is fully synchronous to one clock. A write takes effect when the side's select and write strobe are both high at a clock edge. A read window is open while select and output enable are both high. On the first edge of the window the block captures the flag state as it stands before any write made at that same edge. It then holds the captured value until the window closes. A polling loop must therefore close and reopen the window to see a change. When both sides claim the same free flag at the same edge, a per-flag priority bit decides the winner and then flips.

Top module: `sema_dual_port`

## Requirements
- R1: After reset every flag is free. Both read outputs are 8'h00 while no read window is open, and the first read of any flag from either side returns 8'hFF.
- R2: A write happens only when the side's select and write strobe are both high at a clock edge. Only data bit 0 counts: 0 is a claim and 1 is a release. Bits 7..1 are ignored, and a strobe with select low changes nothing.
- R3: A claim on a free flag gives ownership to the claiming side. That side then reads 8'h00 and the other side reads 8'hFF.
- R4: A claim from the side that does not own the flag leaves ownership unchanged. The owner keeps reading 8'h00 and the claimant reads 8'hFF. The claim is held in the claimant's request latch.
- R5: When the owner releases and the other side has a pending claim, ownership passes to the other side at that same edge. The new owner reads 8'h00 and the former owner reads 8'hFF.
- R6: When the owner releases and no claim is pending, the flag becomes free and reads 8'hFF on both sides.
- R7: The read output changes one edge after the window opens. It shows the side's view of the indexed flag replicated into all 8 bits. It stays constant while the window stays open, even if the flag changes. It returns to 8'h00 one edge after the window closes.
- R8: When both sides claim the same free flag at the same edge, exactly one side wins. The first tie on a flag after reset goes to the left side. Each later tie on that flag goes to the side that lost the previous tie.
- R9: The flags are independent. Operations on one index never change the state or the tie priority of another.
- R10: A write changes only the flag selected by the 3-bit index presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sel | input | 1 | Left side select |
| l_oe | input | 1 | Left side output enable |
| l_we | input | 1 | Left side write strobe |
| l_idx | input | 3 | Left side flag index |
| l_wdata | input | 8 | Left side write data, only bit 0 used |
| l_rdata | output | 8 | Left side read value |
| r_sel | input | 1 | Right side select |
| r_oe | input | 1 | Right side output enable |
| r_we | input | 1 | Right side write strobe |
| r_idx | input | 3 | Right side flag index |
| r_wdata | input | 8 | Right side write data, only bit 0 used |
| r_rdata | output | 8 | Right side read value |

## Verification
Ownership is driven through several patterns. The first is an uncontested claim and release, which separates a free flag from an owned one. The second is a contested claim followed by the owner's release, which tells a pending latch that hands over apart from one that is dropped. The third is a release with nothing pending, which must free the flag. Simultaneous claims on one flag are repeated to show that the tie winner alternates rather than staying fixed, and a tie on a second flag shows that its priority is separate. Writes with select low, with high data bits set, and to neighbouring indices show that only the addressed flag and bit 0 count. A claim made inside an open read window shows the frozen read value apart from the live one.

// File: rtl/sema_pkg.sv
package sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Request latches hold 1 when idle, 0 when a claim is standing.
    typedef struct packed {
        logic   req_l;
        logic   req_r;
        owner_e owner;
        logic   tie_right;   // 1: next tie goes to the right side
    } flag_state_t;

endpackage

// File: rtl/sema_wr_decode.sv
module sema_wr_decode #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                    sel,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [(1<<IDX_W)-1:0]   hit,
    output logic                    wbit
);
    localparam int NFLAG = 1 << IDX_W;

    for (genvar g = 0; g < NFLAG; g++) begin : g_hit
        assign hit[g] = sel && we && (idx == IDX_W'(g));
    end

    assign wbit = wdata[0];
endmodule

// File: rtl/sema_flag.sv
module sema_flag
    import sema_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output logic l_own,
    output logic r_own
);
    flag_state_t st_d, st_q;
    logic        l_claim, r_claim;

    always_comb begin
        st_d = st_q;
        if (l_wr) st_d.req_l = l_bit;
        if (r_wr) st_d.req_r = r_bit;
        l_claim = !st_d.req_l;
        r_claim = !st_d.req_r;

        case (st_q.owner)
            OWN_LEFT: begin
                if (!l_claim) st_d.owner = r_claim ? OWN_RIGHT : OWN_NONE;
            end
            OWN_RIGHT: begin
                if (!r_claim) st_d.owner = l_claim ? OWN_LEFT : OWN_NONE;
            end
            default: begin
                if (l_claim && r_claim) begin
                    st_d.owner     = st_q.tie_right ? OWN_RIGHT : OWN_LEFT;
                    st_d.tie_right = !st_q.tie_right;
                end else if (l_claim) begin
                    st_d.owner = OWN_LEFT;
                end else if (r_claim) begin
                    st_d.owner = OWN_RIGHT;
                end else begin
                    st_d.owner = OWN_NONE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.req_l     <= 1'b1;
            st_q.req_r     <= 1'b1;
            st_q.owner     <= OWN_NONE;
            st_q.tie_right <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_own = (st_q.owner == OWN_LEFT);
    assign r_own = (st_q.owner == OWN_RIGHT);
endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel,
    input  logic                    oe,
    input  logic [IDX_W-1:0]        idx,
    input  logic [(1<<IDX_W)-1:0]   mine,
    output logic [DATA_W-1:0]       rdata
);
    typedef struct packed {
        logic              win;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic      open;

    always_comb begin
        st_d     = st_q;
        open     = sel && oe;
        st_d.win = open;
        if (!open) begin
            st_d.data = '0;
        end else if (!st_q.win) begin
            st_d.data = {DATA_W{!mine[idx]}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.data;
endmodule

// File: rtl/sema_dual_port.sv
module sema_dual_port
    import sema_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel,
    input  logic              l_oe,
    input  logic              l_we,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_oe,
    input  logic              r_we,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int NFLAG = 1 << IDX_W;

    logic [NFLAG-1:0] l_hit, r_hit;
    logic [NFLAG-1:0] own_l, own_r;
    logic             l_bit, r_bit;

    sema_wr_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) l_dec_i (
        .sel(l_sel), .we(l_we), .idx(l_idx), .wdata(l_wdata),
        .hit(l_hit), .wbit(l_bit)
    );

    sema_wr_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) r_dec_i (
        .sel(r_sel), .we(r_we), .idx(r_idx), .wdata(r_wdata),
        .hit(r_hit), .wbit(r_bit)
    );

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sema_flag flag_i (
            .clk(clk), .rst_n(rst_n),
            .l_wr(l_hit[g]), .l_bit(l_bit),
            .r_wr(r_hit[g]), .r_bit(r_bit),
            .l_own(own_l[g]), .r_own(own_r[g])
        );
    end

    sema_rd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) l_rd_i (
        .clk(clk), .rst_n(rst_n), .sel(l_sel), .oe(l_oe), .idx(l_idx),
        .mine(own_l), .rdata(l_rdata)
    );

    sema_rd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) r_rd_i (
        .clk(clk), .rst_n(rst_n), .sel(r_sel), .oe(r_oe), .idx(r_idx),
        .mine(own_r), .rdata(r_rdata)
    );
endmodule

// File: rtl/sema_checker.sv
module sema_checker #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    l_sel,
    input logic                    l_oe,
    input logic                    l_we,
    input logic [IDX_W-1:0]        l_idx,
    input logic [DATA_W-1:0]       l_wdata,
    input logic [DATA_W-1:0]       l_rdata,
    input logic                    r_sel,
    input logic                    r_oe,
    input logic                    r_we,
    input logic [IDX_W-1:0]        r_idx,
    input logic [DATA_W-1:0]       r_wdata,
    input logic [DATA_W-1:0]       r_rdata,
    input logic [(1<<IDX_W)-1:0]   own_l,
    input logic [(1<<IDX_W)-1:0]   own_r
);
    localparam int NFLAG = 1 << IDX_W;
    localparam logic [NFLAG-1:0] ONE = {{(NFLAG-1){1'b0}}, 1'b1};

    logic [NFLAG-1:0] l_rel, r_rel;
    always_comb begin
        l_rel = (l_sel && l_we && l_wdata[0]) ? (ONE << l_idx) : '0;
        r_rel = (r_sel && r_we && r_wdata[0]) ? (ONE << r_idx) : '0;
    end

    p_single_owner_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l & own_r) == '0);

    p_owner_sticky_l_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_l & ~l_rel) != '0) |=> (($past(own_l & ~l_rel) & ~own_l) == '0));

    p_owner_sticky_r_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_r & ~r_rel) != '0) |=> (($past(own_r & ~r_rel) & ~own_r) == '0));

    p_rd_hold_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (l_sel && l_oe && $past(l_sel && l_oe)) |=> $stable(l_rdata));

    p_rd_hold_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sel && r_oe && $past(r_sel && r_oe)) |=> $stable(r_rdata));

    p_rd_idle_l_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_sel && l_oe) |=> (l_rdata == '0));

    p_rd_idle_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_sel && r_oe) |=> (r_rdata == '0));

    p_rd_replicate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_rdata == '0) || (l_rdata == '1)) && ((r_rdata == '0) || (r_rdata == '1)));
endmodule

bind sema_dual_port sema_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/sema_dual_port_tb_top.sv
module sema_dual_port_tb_top;
    localparam real CLK_NS = 4.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       l_sel = 0, l_oe = 0, l_we = 0;
    logic [2:0] l_idx = '0;
    logic [7:0] l_wdata = '0;
    logic [7:0] l_rdata;
    logic       r_sel = 0, r_oe = 0, r_we = 0;
    logic [2:0] r_idx = '0;
    logic [7:0] r_wdata = '0;
    logic [7:0] r_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    sema_dual_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_sel(l_sel), .l_oe(l_oe), .l_we(l_we), .l_idx(l_idx),
        .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_oe(r_oe), .r_we(r_we), .r_idx(r_idx),
        .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input bit right, input logic [2:0] idx, input logic [7:0] d);
        if (right) begin r_sel = 1; r_we = 1; r_idx = idx; r_wdata = d; end
        else       begin l_sel = 1; l_we = 1; l_idx = idx; l_wdata = d; end
        step();
        r_sel = 0; r_we = 0; l_sel = 0; l_we = 0;
    endtask

    task automatic wr_both(input logic [2:0] idx);
        l_sel = 1; l_we = 1; l_idx = idx; l_wdata = 8'h00;
        r_sel = 1; r_we = 1; r_idx = idx; r_wdata = 8'h00;
        step();
        l_sel = 0; l_we = 0; r_sel = 0; r_we = 0;
    endtask

    task automatic rd_chk(input bit right, input logic [2:0] idx,
                          input logic [7:0] exp, input string req);
        logic [7:0] v;
        if (right) begin r_sel = 1; r_oe = 1; r_idx = idx; end
        else       begin l_sel = 1; l_oe = 1; l_idx = idx; end
        step();
        v = right ? r_rdata : l_rdata;
        check(req, v, exp);
        r_sel = 0; r_oe = 0; l_sel = 0; l_oe = 0;
        step();
    endtask

    task automatic t_reset();
        check("R1 idle left", l_rdata, 8'h00);
        check("R1 idle right", r_rdata, 8'h00);
        rd_chk(0, 3'd0, 8'hFF, "R1 left flag0");
        rd_chk(1, 3'd7, 8'hFF, "R1 right flag7");
    endtask

    task automatic t_basic();
        l_sel = 0; l_we = 1; l_idx = 3'd1; l_wdata = 8'h00;
        step();
        l_we = 0;
        rd_chk(0, 3'd1, 8'hFF, "R2 strobe without select");
        wr(0, 3'd1, 8'hFE);
        rd_chk(0, 3'd1, 8'h00, "R3 owner reads zero");
        rd_chk(1, 3'd1, 8'hFF, "R3 other reads ones");
        rd_chk(0, 3'd0, 8'hFF, "R10 neighbour untouched");
        rd_chk(0, 3'd2, 8'hFF, "R10 upper neighbour untouched");
        wr(0, 3'd1, 8'h01);
        rd_chk(0, 3'd1, 8'hFF, "R6 free after release left");
        rd_chk(1, 3'd1, 8'hFF, "R6 free after release right");
        wr(1, 3'd1, 8'hF0);
        rd_chk(1, 3'd1, 8'h00, "R2 bit0 only claim");
        wr(1, 3'd1, 8'h0F);
        rd_chk(1, 3'd1, 8'hFF, "R2 bit0 only release");
    endtask

    task automatic t_pending();
        wr(0, 3'd2, 8'h00);
        wr(1, 3'd2, 8'h00);
        rd_chk(0, 3'd2, 8'h00, "R4 owner keeps flag");
        rd_chk(1, 3'd2, 8'hFF, "R4 claimant refused");
        wr(0, 3'd2, 8'h01);
        rd_chk(1, 3'd2, 8'h00, "R5 pending side takes over");
        rd_chk(0, 3'd2, 8'hFF, "R5 former owner sees ones");
        wr(1, 3'd2, 8'h01);
        rd_chk(0, 3'd2, 8'hFF, "R6 free left");
        rd_chk(1, 3'd2, 8'hFF, "R6 free right");
    endtask

    task automatic t_hold();
        l_sel = 1; l_oe = 1; l_idx = 3'd4;
        step();
        check("R7 capture free", l_rdata, 8'hFF);
        l_we = 1; l_wdata = 8'h00;
        step();
        l_we = 0;
        step();
        check("R7 frozen during window", l_rdata, 8'hFF);
        l_sel = 0; l_oe = 0;
        step();
        check("R7 idle after close", l_rdata, 8'h00);
        rd_chk(0, 3'd4, 8'h00, "R7 reopen sees claim");
        wr(0, 3'd4, 8'h01);
    endtask

    task automatic t_tie();
        wr_both(3'd3);
        rd_chk(0, 3'd3, 8'h00, "R8 first tie to left");
        rd_chk(1, 3'd3, 8'hFF, "R8 first tie right loses");
        wr(0, 3'd3, 8'h01);
        rd_chk(1, 3'd3, 8'h00, "R5 tie loser takes over");
        wr(1, 3'd3, 8'h01);
        rd_chk(0, 3'd3, 8'hFF, "R6 free after tie sequence");
        wr_both(3'd3);
        rd_chk(1, 3'd3, 8'h00, "R8 second tie to right");
        rd_chk(0, 3'd3, 8'hFF, "R8 second tie left loses");
        wr_both(3'd6);
        rd_chk(0, 3'd6, 8'h00, "R9 other flag own tie priority");
        wr(1, 3'd3, 8'h01); wr(0, 3'd3, 8'h01);
        wr(0, 3'd6, 8'h01); wr(1, 3'd6, 8'h01);
        rd_chk(0, 3'd3, 8'hFF, "R6 flag3 freed");
        rd_chk(1, 3'd6, 8'hFF, "R6 flag6 freed");
    endtask

    task automatic t_indep();
        wr(0, 3'd5, 8'h00);
        wr(1, 3'd4, 8'h00);
        rd_chk(0, 3'd5, 8'h00, "R9 left owns 5");
        rd_chk(1, 3'd5, 8'hFF, "R9 right sees 5 taken");
        rd_chk(1, 3'd4, 8'h00, "R9 right owns 4");
        rd_chk(0, 3'd4, 8'hFF, "R9 left sees 4 taken");
        rd_chk(0, 3'd6, 8'hFF, "R9 flag6 untouched");
        wr(0, 3'd5, 8'h01); wr(1, 3'd4, 8'h01);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_basic();
        t_pending();
        t_hold();
        t_tie();
        t_indep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule